// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block carries out one complete write access to a four-bank single-data-rate SDRAM. A client offers a request made of a bank, a row, a starting column, four data words and two option bits through a valid/ready handshake. The sequencer then drives the memory command pins itself. It opens the row with ACTIVE and waits out the row-to-column delay. It then issues WRITE with auto precharge turned off and places the four data words on four consecutive clocks, the first in the same cycle as WRITE. After the write-recovery gap it closes the row with an explicit PRECHARGE. It holds off the next ACTIVE until the precharge time has passed.

Row-to-column delay, precharge time, minimum active-to-precharge time and active-to-active time are parameters in clocks. The sequencer lengthens its NOP gaps until every one of them is met. Write recovery is one clock when the memory clock is slow and two clocks when `cfg_fast_clk` is set. A request bit chooses whether the PRECHARGE closes only the addressed bank or every bank. A `done` pulse marks the last cycle before the next ACTIVE may legally appear.

Top module: `sdram_wr_seq`

Below, cycle 0 is the first clock cycle in which the ACTIVE for an accepted request is on the pins. p = max(T_RCD + 3 + W, T_RAS), where W is 1 when `cfg_fast_clk` is 0 and 2 when it is 1. a = max(p + T_RP, T_RC).

## Requirements
- R1: After reset is released the outputs show NOP, `sd_dq_oe` low, `sd_dqm` all ones, `req_ready` high and `done` low. `sd_cke` is low while reset is held and high from the first clock after it.
- R2: The command is encoded on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} as ACTIVE=0011, WRITE=0100, PRECHARGE=0010 and NOP=0111. Every cycle that R3, R4 and R6 do not name carries NOP, including all idle cycles.
- R3: A request accepted at a clock edge (`req_valid` and `req_ready` both high) puts ACTIVE on the pins in the cycle that follows, which is cycle 0. In that cycle `sd_addr` carries the full row and `sd_ba` carries the bank.
- R4: WRITE appears in cycle T_RCD. `sd_addr` then carries the column, zero-extended, so address bit 10 is low (auto precharge off) and the bits above the column are 0. `sd_ba` carries the bank.
- R5: In cycles T_RCD to T_RCD+3, `sd_dq_oe` is high, `sd_dqm` is 0 and `sd_dq_out` carries data word k = `req_data[32k+31:32k]` in cycle T_RCD+k. In every other cycle `sd_dq_oe` is low, `sd_dqm` is all ones and `sd_dq_out` is 0.
- R6: PRECHARGE appears in cycle p. The write recovery W is sampled at acceptance from `cfg_fast_clk`.
- R7: At PRECHARGE, address bit 10 equals `req_all_banks` (1 = all banks, 0 = the bank on `sd_ba`). The other address bits are 0, and `sd_ba` carries the request's bank.
- R8: `done` is high in cycle a-1 only. A request accepted in that cycle shows its ACTIVE in cycle a, so ACTIVE-to-ACTIVE spacing is at least T_RC and PRECHARGE-to-ACTIVE spacing is at least T_RP.
- R9: `req_ready` is high only in cycle a-1 and while idle. A request offered while the sequencer is busy is not taken, and changes on the request inputs during an access do not alter that access's commands, addresses or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ADDR_W | Row to open |
| req_col | input | COL_W | Starting column of the burst |
| req_data | input | BURST_LEN*DATA_W | Burst data, word 0 in the low bits |
| req_all_banks | input | 1 | PRECHARGE closes all banks when set |
| cfg_fast_clk | input | 1 | Selects two-clock write recovery |
| done | output | 1 | Access finished, next ACTIVE legal next cycle |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed address |
| sd_dqm | output | DATA_W/8 | Byte masks, high = masked |
| sd_dq_out | output | DATA_W | Write data toward the data pins |
| sd_dq_oe | output | 1 | Output enable for the data pins |

## Verification
The bench builds two copies side by side. The first uses the default timing (T_RCD=2, T_RP=2, T_RAS=4, T_RC=8), where the burst and write recovery set the PRECHARGE cycle and the one-clock against two-clock recovery choice is visible. The second uses T_RCD=3, T_RP=3, T_RAS=10 and T_RC=16, where the active-to-precharge and active-to-active limits dominate. In that copy the NOP gaps are stretched and the recovery setting no longer moves the PRECHARGE cycle. A back-to-back run on the first copy shows the next ACTIVE landing exactly on the earliest legal cycle while changed request inputs leave the access in flight untouched.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_NOP = 4'b0111,
      CMD_ACT = 4'b0011,
      CMD_WR  = 4'b0100,
      CMD_PRE = 4'b0010
   } sd_cmd_e;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_wr_timer.sv
// Cycle counter of one access. Flags describe the cycle whose outputs are
// being registered at the coming edge.
module sdram_wr_timer #(
   parameter int T_RCD     = 2,
   parameter int BURST_LEN = 4,
   parameter int P_SLOW    = 6,
   parameter int P_FAST    = 7,
   parameter int A_SLOW    = 8,
   parameter int A_FAST    = 9,
   parameter int CNT_W     = 4,
   parameter int BI_W      = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            busy_i,
   input  logic            rec2_i,
   output logic            wr_o,
   output logic            beat_o,
   output logic [BI_W-1:0] beat_idx_o,
   output logic            pre_o,
   output logic            last_o
);
   localparam logic [CNT_W-1:0] C_RCD   = CNT_W'(T_RCD);
   localparam logic [CNT_W-1:0] C_BEND  = CNT_W'(T_RCD + BURST_LEN);
   localparam logic [CNT_W-1:0] C_PSLOW = CNT_W'(P_SLOW);
   localparam logic [CNT_W-1:0] C_PFAST = CNT_W'(P_FAST);
   localparam logic [CNT_W-1:0] C_LSLOW = CNT_W'(A_SLOW - 1);
   localparam logic [CNT_W-1:0] C_LFAST = CNT_W'(A_FAST - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W-1:0] pre_at;
   logic [CNT_W-1:0] last_at;
   logic             rec2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rec2_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= '0;
         rec2_q <= rec2_i;
      end else if (busy_i) begin
         cnt_q  <= nxt;
      end
   end

   always_comb begin
      nxt        = start_i ? '0 : cnt_q + 1'b1;
      pre_at     = rec2_q ? C_PFAST : C_PSLOW;
      last_at    = rec2_q ? C_LFAST : C_LSLOW;
      wr_o       = busy_i && (nxt == C_RCD);
      beat_o     = busy_i && (nxt >= C_RCD) && (nxt < C_BEND);
      beat_idx_o = BI_W'(nxt - C_RCD);
      pre_o      = busy_i && (nxt == pre_at);
      last_o     = busy_i && (nxt == last_at);
   end

   // R5: the burst continues in the cycle after the WRITE is scheduled
   a_r5_beat_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |=> beat_o);

   // R6: precharge is never scheduled while data beats are still pending
   a_r6_pre_not_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      pre_o |-> !beat_o);

endmodule

// File: rtl/sdram_wr_beatsel.sv
// Picks one burst word out of the flat request data.
module sdram_wr_beatsel #(
   parameter int DATA_W    = 32,
   parameter int BURST_LEN = 4,
   parameter int BI_W      = 2
) (
   input  logic [BURST_LEN*DATA_W-1:0] words_i,
   input  logic [BI_W-1:0]             idx_i,
   output logic [DATA_W-1:0]           word_o
);
   logic [DATA_W-1:0] word_arr [BURST_LEN];

   for (genvar g = 0; g < BURST_LEN; g++) begin : g_word
      assign word_arr[g] = words_i[g*DATA_W +: DATA_W];
   end

   always_comb word_o = word_arr[idx_i];

endmodule

// File: rtl/sdram_wr_cmdgen.sv
// Registered drive of the memory command, address and data pins.
module sdram_wr_cmdgen
   import sdram_wr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int COL_W  = 8,
   parameter int BANK_W = 2,
   parameter int DATA_W = 32,
   parameter int AP_BIT = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                wr_i,
   input  logic                beat_i,
   input  logic                pre_i,
   input  logic [ADDR_W-1:0]   row_i,
   input  logic [BANK_W-1:0]   bank_i,
   input  logic [COL_W-1:0]    col_i,
   input  logic                all_i,
   input  logic [DATA_W-1:0]   word_i,
   output sd_cmd_e             cmd_o,
   output logic [ADDR_W-1:0]   addr_o,
   output logic [BANK_W-1:0]   ba_o,
   output logic [DATA_W/8-1:0] dqm_o,
   output logic [DATA_W-1:0]   dq_o,
   output logic                oe_o,
   output logic                cke_o
);
   logic [BANK_W-1:0] bank_q;
   logic [COL_W-1:0]  col_q;
   logic              all_q;
   logic [ADDR_W-1:0] col_addr;
   logic [ADDR_W-1:0] pre_addr;

   always_comb begin
      col_addr         = ADDR_W'(col_q);
      pre_addr         = '0;
      pre_addr[AP_BIT] = all_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         col_q  <= '0;
         all_q  <= 1'b0;
      end else if (start_i) begin
         bank_q <= bank_i;
         col_q  <= col_i;
         all_q  <= all_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_o  <= CMD_NOP;
         addr_o <= '0;
         ba_o   <= '0;
         dqm_o  <= '1;
         dq_o   <= '0;
         oe_o   <= 1'b0;
         cke_o  <= 1'b0;
      end else begin
         cke_o <= 1'b1;
         if (start_i) begin
            cmd_o  <= CMD_ACT;
            addr_o <= row_i;
            ba_o   <= bank_i;
         end else if (wr_i) begin
            cmd_o  <= CMD_WR;
            addr_o <= col_addr;
            ba_o   <= bank_q;
         end else if (pre_i) begin
            cmd_o  <= CMD_PRE;
            addr_o <= pre_addr;
            ba_o   <= bank_q;
         end else begin
            cmd_o  <= CMD_NOP;
            addr_o <= '0;
            ba_o   <= '0;
         end
         oe_o  <= beat_i;
         dq_o  <= beat_i ? word_i : '0;
         dqm_o <= beat_i ? '0 : '1;
      end
   end

   // R4: a WRITE never requests auto precharge
   a_r4_wr_ap_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_WR) |-> (addr_o[AP_BIT] == 1'b0));

   // R5: the first data beat shares its cycle with the WRITE
   a_r5_wr_with_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == CMD_WR) |-> (oe_o && (dqm_o == '0)));

endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
   import sdram_wr_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int COL_W     = 8,
   parameter int BANK_W    = 2,
   parameter int DATA_W    = 32,
   parameter int BURST_LEN = 4,
   parameter int AP_BIT    = 10,
   parameter int T_RCD     = 2,
   parameter int T_RP      = 2,
   parameter int T_RAS     = 4,
   parameter int T_RC      = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [BANK_W-1:0]             req_bank,
   input  logic [ADDR_W-1:0]             req_row,
   input  logic [COL_W-1:0]              req_col,
   input  logic [BURST_LEN*DATA_W-1:0]   req_data,
   input  logic                          req_all_banks,
   input  logic                          cfg_fast_clk,
   output logic                          done,
   output logic                          sd_cke,
   output logic                          sd_cs_n,
   output logic                          sd_ras_n,
   output logic                          sd_cas_n,
   output logic                          sd_we_n,
   output logic [BANK_W-1:0]             sd_ba,
   output logic [ADDR_W-1:0]             sd_addr,
   output logic [DATA_W/8-1:0]           sd_dqm,
   output logic [DATA_W-1:0]             sd_dq_out,
   output logic                          sd_dq_oe
);
   localparam int BI_W   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
   localparam int P_SLOW = imax(T_RCD + BURST_LEN, T_RAS);
   localparam int P_FAST = imax(T_RCD + BURST_LEN + 1, T_RAS);
   localparam int A_SLOW = imax(P_SLOW + T_RP, T_RC);
   localparam int A_FAST = imax(P_FAST + T_RP, T_RC);
   localparam int CNT_W  = $clog2(A_FAST + 1);
   localparam int GAP_W  = CNT_W + 1;

   // elaboration-time parameter checks
   if (T_RCD < 1)                 begin : g_bad_rcd   $error("T_RCD must be at least 1");        end
   if (T_RP < 1)                  begin : g_bad_rp    $error("T_RP must be at least 1");         end
   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0)
                                  begin : g_bad_bl    $error("BURST_LEN must be a power of two >= 2"); end
   if (DATA_W % 8 != 0)           begin : g_bad_dw    $error("DATA_W must be whole bytes");      end
   if (AP_BIT >= ADDR_W)          begin : g_bad_ap    $error("AP_BIT outside the address");      end
   if (COL_W > AP_BIT)            begin : g_bad_col   $error("column would overlap AP_BIT");     end

   seq_state_e                  state_q;
   logic                        accept;
   logic                        busy;
   logic [BURST_LEN*DATA_W-1:0] data_q;
   logic                        done_q;
   logic                        t_wr, t_beat, t_pre, t_last;
   logic [BI_W-1:0]             t_idx;
   logic [DATA_W-1:0]           beat_word;
   sd_cmd_e                     cmd;

   assign req_ready = (state_q == SEQ_IDLE);
   assign accept    = req_valid && req_ready;
   assign busy      = (state_q == SEQ_BUSY);
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         done_q  <= 1'b0;
         data_q  <= '0;
      end else begin
         done_q <= t_last;
         if (accept) begin
            state_q <= SEQ_BUSY;
            data_q  <= req_data;
         end else if (t_last) begin
            state_q <= SEQ_IDLE;
         end
      end
   end

   sdram_wr_timer #(
      .T_RCD(T_RCD), .BURST_LEN(BURST_LEN),
      .P_SLOW(P_SLOW), .P_FAST(P_FAST), .A_SLOW(A_SLOW), .A_FAST(A_FAST),
      .CNT_W(CNT_W), .BI_W(BI_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(accept), .busy_i(busy),
      .rec2_i(cfg_fast_clk), .wr_o(t_wr), .beat_o(t_beat),
      .beat_idx_o(t_idx), .pre_o(t_pre), .last_o(t_last)
   );

   sdram_wr_beatsel #(
      .DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .BI_W(BI_W)
   ) u_beatsel (
      .words_i(data_q), .idx_i(t_idx), .word_o(beat_word)
   );

   sdram_wr_cmdgen #(
      .ADDR_W(ADDR_W), .COL_W(COL_W), .BANK_W(BANK_W),
      .DATA_W(DATA_W), .AP_BIT(AP_BIT)
   ) u_cmdgen (
      .clk(clk), .rst_n(rst_n), .start_i(accept), .wr_i(t_wr),
      .beat_i(t_beat), .pre_i(t_pre), .row_i(req_row), .bank_i(req_bank),
      .col_i(req_col), .all_i(req_all_banks), .word_i(beat_word),
      .cmd_o(cmd), .addr_o(sd_addr), .ba_o(sd_ba), .dqm_o(sd_dqm),
      .dq_o(sd_dq_out), .oe_o(sd_dq_oe), .cke_o(sd_cke)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

   // spacing monitors for the pin-level timing assertions
   localparam logic [GAP_W-1:0] G_RP  = GAP_W'(T_RP);
   localparam logic [GAP_W-1:0] G_RC  = GAP_W'(T_RC);
   localparam logic [GAP_W-1:0] G_RAS = GAP_W'(T_RAS);
   logic [GAP_W-1:0] gap_pre_q;
   logic [GAP_W-1:0] gap_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_pre_q <= '1;
         gap_act_q <= '1;
      end else begin
         if (cmd == CMD_PRE)        gap_pre_q <= GAP_W'(1);
         else if (gap_pre_q != '1)  gap_pre_q <= gap_pre_q + 1'b1;
         if (cmd == CMD_ACT)        gap_act_q <= GAP_W'(1);
         else if (gap_act_q != '1)  gap_act_q <= gap_act_q + 1'b1;
      end
   end

   a_r8_trp: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |-> (gap_pre_q >= G_RP));

   a_r8_trc: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |-> (gap_act_q >= G_RC));

   a_r6_tras: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE) |-> (gap_act_q >= G_RAS));

   a_r9_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !done) |-> ((cmd == CMD_NOP) && !sd_dq_oe));

endmodule

// File: tb/sdram_wr_seq_test.sv
module sdram_wr_seq_test;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n;
   logic [1:0]   vld;
   logic [1:0]   b_in;
   logic [11:0]  r_in;
   logic [7:0]   c_in;
   logic [127:0] d_in;
   logic         all_in, fast_in;

   logic         rdy [2];
   logic         dn  [2];
   logic         cke [2];
   logic [3:0]   cmdv [2];
   logic [1:0]   bav [2];
   logic [11:0]  addrv [2];
   logic [3:0]   dqmv [2];
   logic [31:0]  dqv [2];
   logic         oev [2];

   int n_chk  = 0;
   int n_fail = 0;

   int rcd_t [2] = '{2, 3};
   int rp_t  [2] = '{2, 3};
   int ras_t [2] = '{4, 10};
   int rc_t  [2] = '{8, 16};

   sdram_wr_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(vld[0]), .req_ready(rdy[0]),
      .req_bank(b_in), .req_row(r_in), .req_col(c_in), .req_data(d_in),
      .req_all_banks(all_in), .cfg_fast_clk(fast_in), .done(dn[0]),
      .sd_cke(cke[0]), .sd_cs_n(cmdv[0][3]), .sd_ras_n(cmdv[0][2]),
      .sd_cas_n(cmdv[0][1]), .sd_we_n(cmdv[0][0]), .sd_ba(bav[0]),
      .sd_addr(addrv[0]), .sd_dqm(dqmv[0]), .sd_dq_out(dqv[0]), .sd_dq_oe(oev[0])
   );

   sdram_wr_seq #(.T_RCD(3), .T_RP(3), .T_RAS(10), .T_RC(16)) uut_long (
      .clk(clk), .rst_n(rst_n), .req_valid(vld[1]), .req_ready(rdy[1]),
      .req_bank(b_in), .req_row(r_in), .req_col(c_in), .req_data(d_in),
      .req_all_banks(all_in), .cfg_fast_clk(fast_in), .done(dn[1]),
      .sd_cke(cke[1]), .sd_cs_n(cmdv[1][3]), .sd_ras_n(cmdv[1][2]),
      .sd_cas_n(cmdv[1][1]), .sd_we_n(cmdv[1][0]), .sd_ba(bav[1]),
      .sd_addr(addrv[1]), .sd_dqm(dqmv[1]), .sd_dq_out(dqv[1]), .sd_dq_oe(oev[1])
   );

   localparam logic [3:0] E_NOP = 4'b0111, E_ACT = 4'b0011, E_WR = 4'b0100, E_PRE = 4'b0010;

   task automatic chk(input string tag, input string what,
                      input logic [127:0] got, input logic [127:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   function automatic int exp_pre(input int k, input logic fast);
      int v = rcd_t[k] + 3 + (fast ? 2 : 1);
      return (v > ras_t[k]) ? v : ras_t[k];
   endfunction

   function automatic int exp_end(input int k, input logic fast);
      int v = exp_pre(k, fast) + rp_t[k];
      return (v > rc_t[k]) ? v : rc_t[k];
   endfunction

   // Called at the falling edge of cycle 0; returns at the falling edge of cycle a.
   task automatic check_seq(input int k, input logic [1:0] b, input logic [11:0] r,
                            input logic [7:0] c, input logic [127:0] d,
                            input logic fast, input logic all);
      int rcd = rcd_t[k];
      int p   = exp_pre(k, fast);
      int a   = exp_end(k, fast);
      for (int cyc = 0; cyc < a; cyc++) begin
         logic [3:0] ec;
         bit beat;
         ec   = (cyc == 0) ? E_ACT : (cyc == rcd) ? E_WR : (cyc == p) ? E_PRE : E_NOP;
         beat = (cyc >= rcd) && (cyc < rcd + 4);
         chk((cyc == 0) ? "R3" : (cyc == rcd) ? "R4" : (cyc == p) ? "R6" : "R2",
             $sformatf("inst%0d cmd cycle %0d", k, cyc), cmdv[k], ec);
         chk("R5", $sformatf("inst%0d oe cycle %0d", k, cyc), oev[k], beat);
         chk("R5", $sformatf("inst%0d dqm cycle %0d", k, cyc), dqmv[k], beat ? 4'h0 : 4'hF);
         chk("R5", $sformatf("inst%0d dq cycle %0d", k, cyc), dqv[k],
             beat ? d[(cyc-rcd)*32 +: 32] : 32'h0);
         if (cyc == 0) begin
            chk("R3", "ACTIVE row", addrv[k], r);
            chk("R3", "ACTIVE bank", bav[k], b);
         end
         if (cyc == rcd) begin
            chk("R4", "WRITE column, A10 low", addrv[k], {4'h0, c});
            chk("R4", "WRITE bank", bav[k], b);
         end
         if (cyc == p) begin
            chk("R7", "PRECHARGE address", addrv[k], all ? 12'h400 : 12'h000);
            chk("R7", "PRECHARGE bank", bav[k], b);
         end
         chk("R8", $sformatf("inst%0d done cycle %0d", k, cyc), dn[k], cyc == a - 1);
         chk("R9", $sformatf("inst%0d ready cycle %0d", k, cyc), rdy[k], cyc == a - 1);
         @(negedge clk);
      end
   endtask

   task automatic do_burst(input int k, input logic [1:0] b, input logic [11:0] r,
                           input logic [7:0] c, input logic [127:0] d,
                           input logic fast, input logic all);
      while (!rdy[k]) @(negedge clk);
      b_in = b; r_in = r; c_in = c; d_in = d; fast_in = fast; all_in = all;
      vld[k] = 1'b1;
      @(negedge clk);
      vld[k] = 1'b0;
      check_seq(k, b, r, c, d, fast, all);
   endtask

   task automatic idle_quiet(input int k);
      for (int i = 0; i < 4; i++) begin
         chk("R2", "idle command", cmdv[k], E_NOP);
         chk("R9", "idle ready", rdy[k], 1'b1);
         chk("R5", "idle oe", oev[k], 1'b0);
         @(negedge clk);
      end
   endtask

   task automatic test_reset();
      rst_n = 1'b0;
      vld = 2'b00; b_in = '0; r_in = '0; c_in = '0; d_in = '0; fast_in = 0; all_in = 0;
      repeat (3) @(negedge clk);
      for (int k = 0; k < 2; k++) chk("R1", "cke in reset", cke[k], 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         chk("R1", "cke after reset", cke[k], 1'b1);
         chk("R1", "command after reset", cmdv[k], E_NOP);
         chk("R1", "oe after reset", oev[k], 1'b0);
         chk("R1", "dqm after reset", dqmv[k], 4'hF);
         chk("R1", "ready after reset", rdy[k], 1'b1);
         chk("R1", "done after reset", dn[k], 1'b0);
      end
   endtask

   // R9: second request held valid through the first access
   task automatic test_back_to_back();
      logic [127:0] da = 128'h0D0D0D03_0C0C0C02_0B0B0B01_0A0A0A00;
      logic [127:0] db = 128'hF0000004_E0000003_D0000002_C0000001;
      while (!rdy[0]) @(negedge clk);
      b_in = 2'd1; r_in = 12'h123; c_in = 8'h40; d_in = da; fast_in = 0; all_in = 0;
      vld[0] = 1'b1;
      @(negedge clk);
      b_in = 2'd3; r_in = 12'h7E1; c_in = 8'h0F; d_in = db; fast_in = 1; all_in = 1;
      check_seq(0, 2'd1, 12'h123, 8'h40, da, 1'b0, 1'b0);
      vld[0] = 1'b0;
      check_seq(0, 2'd3, 12'h7E1, 8'h0F, db, 1'b1, 1'b1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      test_reset();
      idle_quiet(0);
      do_burst(0, 2'd2, 12'hA5C, 8'h3D, 128'hDDDD0003_CCCC0002_BBBB0001_AAAA0000, 1'b0, 1'b0);
      do_burst(0, 2'd1, 12'h0F0, 8'h80, 128'h11112222_33334444_55556666_77778888, 1'b1, 1'b1);
      do_burst(0, 2'd3, 12'hFFF, 8'hFF, 128'hFFFFFFFF_00000000_A5A5A5A5_5A5A5A5A, 1'b0, 1'b1);
      test_back_to_back();
      idle_quiet(0);
      do_burst(1, 2'd0, 12'h400, 8'h01, 128'h01234567_89ABCDEF_FEDCBA98_76543210, 1'b0, 1'b0);
      do_burst(1, 2'd2, 12'h3AA, 8'hC3, 128'hCAFE0004_CAFE0003_CAFE0002_CAFE0001, 1'b1, 1'b1);
      idle_quiet(1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule